// File: doc/BRIEF.md
# Transfer Credit and Byte Total Counters

This block sits on the device side of a host-driven packet link and keeps two running totals. The first counts how many receive buffers local logic has handed over for the host to fill. The second is a byte total of everything local logic has queued for the host to read back. Local logic bumps the credit count with a one-cycle pulse. It grows the byte total with a strobe that carries a length.

Neither total is ever decremented. The host keeps its own tally of buffers filled and bytes fetched, and works out what is left by modular subtraction. When the host fills part of a buffer at the end of a write, that buffer counts as one whole consumed buffer. Both totals are read through a simple register-read port with one cycle of latency. Any address the port does not decode returns zero.

Top module: `xfer_acct_top`

## Requirements
- R1: A synchronous active-high reset clears both totals, so the first reads after reset return zero at both offsets.
- R2: Each cycle with `buf_loaded` high adds one to the credit count. A read at offset 0x044 returns the count in bits 27:16, with every other bit zero.
- R3: The credit count wraps modulo 4096. The host's free-buffer figure, credit minus whole buffers consumed, is taken modulo 4096 and stays correct across the wrap.
- R4: Each cycle with `bytes_queued` high adds `queue_len` to the byte total. A read at offset 0x060 returns the full 32-bit total.
- R5: The byte total wraps modulo 2^32.
- R6: `rd_valid` and `rd_data` change one cycle after a cycle with `rd_en` high. The data is the total as it stood before any increment in the request cycle. It is held unchanged until the next read.
- R7: A read at any offset other than 0x044 or 0x060 returns zero.
- R8: A credit pulse and a byte strobe in the same cycle are both applied in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_loaded | input | 1 | One-cycle pulse: one more receive buffer is available |
| bytes_queued | input | 1 | Strobe: `queue_len` more bytes are queued for the host |
| queue_len | input | LEN_W (16) | Byte count added when `bytes_queued` is high |
| rd_en | input | 1 | Register read request |
| rd_addr | input | ADDR_W (12) | Byte offset of the register to read |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High in the cycle after a read request |

## Verification
A register read can fall in the same cycle as a credit pulse or a byte strobe. The bench provokes this by raising `rd_en` on the credit offset in the same cycle as `buf_loaded`. It expects the returned word to show the count from before the pulse, and a second read to show the incremented count. The bench also raises both increment inputs in the same cycle, and judges each total on its own against a running model.

// File: rtl/xfer_acct_pkg.sv
package xfer_acct_pkg;
  // Register offsets decoded by the host; the byte offsets are part of the link contract.
  localparam int unsigned CREDIT_OFS = 32'h044;
  localparam int unsigned TOTAL_OFS  = 32'h060;
  localparam int unsigned WORD_W     = 32;
endpackage

// File: rtl/xfer_credit_cnt.sv
module xfer_credit_cnt #(
  parameter int CREDIT_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inc,
  output logic [CREDIT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  assert_reset_R1: assert property (@(posedge clk) rst |=> count == '0);
  assert_inc_R2: assert property (@(posedge clk) disable iff (rst)
    inc |=> count == CREDIT_W'($past(count) + 1'b1));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count));
endmodule

// File: rtl/xfer_byte_total.sv
module xfer_byte_total #(
  parameter int LEN_W   = 16,
  parameter int TOTAL_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               add,
  input  logic [LEN_W-1:0]   len,
  output logic [TOTAL_W-1:0] total
);
  localparam int PAD_W = TOTAL_W - LEN_W;

  logic [TOTAL_W-1:0] len_ext;
  assign len_ext = {{PAD_W{1'b0}}, len};

  always_ff @(posedge clk) begin
    if (rst)      total <= '0;
    else if (add) total <= total + len_ext;
  end

  assert_reset_R1: assert property (@(posedge clk) rst |=> total == '0);
  assert_add_R4: assert property (@(posedge clk) disable iff (rst)
    add |=> total == TOTAL_W'($past(total) + {{PAD_W{1'b0}}, $past(len)}));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !add |=> $stable(total));
endmodule

// File: rtl/xfer_reg_read.sv
module xfer_reg_read
  import xfer_acct_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int CREDIT_W   = 12,
  parameter int CREDIT_LSB = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [CREDIT_W-1:0] credit,
  input  logic [WORD_W-1:0]   total,
  output logic [WORD_W-1:0]   rd_data,
  output logic                rd_valid
);
  logic [WORD_W-1:0] credit_word;
  logic [WORD_W-1:0] sel_word;
  logic              hit_credit;
  logic              hit_total;

  always_comb begin
    credit_word = '0;
    credit_word[CREDIT_LSB +: CREDIT_W] = credit;
  end

  assign hit_credit = (int'(rd_addr) == CREDIT_OFS);
  assign hit_total  = (int'(rd_addr) == TOTAL_OFS);

  always_comb begin
    if (hit_credit)     sel_word = credit_word;
    else if (hit_total) sel_word = total;
    else                sel_word = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel_word;
    end
  end

  assert_valid_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_held_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  assert_total_R4: assert property (@(posedge clk) disable iff (rst)
    rd_en && hit_total |=> rd_data == $past(total));
  assert_unmapped_R7: assert property (@(posedge clk) disable iff (rst)
    rd_en && !hit_credit && !hit_total |=> rd_data == '0);
endmodule

// File: rtl/xfer_acct_top.sv
module xfer_acct_top
  import xfer_acct_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int CREDIT_W   = 12,
  parameter int CREDIT_LSB = 16,
  parameter int LEN_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              buf_loaded,
  input  logic              bytes_queued,
  input  logic [LEN_W-1:0]  queue_len,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              rd_valid
);
  logic [CREDIT_W-1:0] credit;
  logic [WORD_W-1:0]   total;

  xfer_credit_cnt #(.CREDIT_W(CREDIT_W)) i_credit (
    .clk(clk), .rst(rst), .inc(buf_loaded), .count(credit)
  );

  xfer_byte_total #(.LEN_W(LEN_W), .TOTAL_W(WORD_W)) i_total (
    .clk(clk), .rst(rst), .add(bytes_queued), .len(queue_len), .total(total)
  );

  xfer_reg_read #(.ADDR_W(ADDR_W), .CREDIT_W(CREDIT_W), .CREDIT_LSB(CREDIT_LSB)) i_read (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .credit(credit), .total(total), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R8: both increments in one cycle land together.
  assert_both_R8: assert property (@(posedge clk) disable iff (rst)
    buf_loaded && bytes_queued |=> !$stable(credit) && (total == WORD_W'($past(total) + $past(queue_len))));
endmodule

// File: tb/test_xfer_acct_top.sv
module test_xfer_acct_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    logic        ld;
    logic        st;
    logic [15:0] len;
    logic [11:0] exp_credit;
    logic [31:0] exp_total;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 16'd0,     12'd1, 32'd0},
    '{1'b0, 1'b1, 16'd100,   12'd1, 32'd100},
    '{1'b1, 1'b1, 16'd28,    12'd2, 32'd128},   // R8 both in one cycle
    '{1'b1, 1'b1, 16'hFFFF,  12'd3, 32'd65663},
    '{1'b0, 1'b0, 16'd0,     12'd3, 32'd65663},
    '{1'b1, 1'b0, 16'd0,     12'd4, 32'd65663}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        buf_loaded = 1'b0;
  logic        bytes_queued = 1'b0;
  logic [15:0] queue_len = '0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  xfer_acct_top i_xfer_acct_top (
    .clk(clk), .rst(rst), .buf_loaded(buf_loaded), .bytes_queued(bytes_queued),
    .queue_len(queue_len), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic do_read(input logic [11:0] addr, output logic [31:0] d);
    rd_en = 1'b1;
    rd_addr = addr;
    @(negedge clk);
    rd_en = 1'b0;
    checks++;
    if (rd_valid !== 1'b1) begin
      failures++;
      $display("FAIL R6 rd_valid actual=%b expected=1", rd_valid);
    end
    d = rd_data;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [11:0] free_bufs;
    int          consumed;
    @(negedge clk);
    do_reset();

    // R1 reset state
    do_read(12'h044, d); check("R1 credit after reset", d, 32'd0);
    do_read(12'h060, d); check("R1 total after reset", d, 32'd0);

    // Table walk: R2, R4, R8
    foreach (VECS[i]) begin
      buf_loaded = VECS[i].ld;
      bytes_queued = VECS[i].st;
      queue_len = VECS[i].len;
      @(negedge clk);
      buf_loaded = 1'b0;
      bytes_queued = 1'b0;
      do_read(12'h044, d); check("R2 credit field", d, {4'd0, VECS[i].exp_credit, 16'd0});
      do_read(12'h060, d); check("R4 byte total", d, VECS[i].exp_total);
    end

    // R2 host free-buffer figure: 1031 bytes in 512-byte buffers uses 3 whole buffers
    consumed = (1031 + 511) / 512;
    do_read(12'h044, d);
    free_bufs = d[27:16] - 12'(consumed);
    check("R2 free buffers", {20'd0, free_bufs}, 32'd1);

    // R7 unmapped offsets read zero
    do_read(12'h048, d); check("R7 unmapped 0x048", d, 32'd0);
    do_read(12'h040, d); check("R7 unmapped 0x040", d, 32'd0);

    // R6 read in the same cycle as a credit pulse returns the earlier count
    buf_loaded = 1'b1;
    do_read(12'h044, d);
    buf_loaded = 1'b0;
    check("R6 read-with-pulse old value", d, {4'd0, 12'd4, 16'd0});
    @(negedge clk);
    check("R6 data held", rd_data, {4'd0, 12'd4, 16'd0});
    do_read(12'h044, d); check("R6 next read new value", d, {4'd0, 12'd5, 16'd0});

    // R1 reset after activity
    do_reset();
    do_read(12'h044, d); check("R1 credit cleared", d, 32'd0);
    do_read(12'h060, d); check("R1 total cleared", d, 32'd0);

    // R3 credit wrap: 4098 pulses read as 2; 4097 consumed leaves 1 free
    buf_loaded = 1'b1;
    repeat (4098) @(negedge clk);
    buf_loaded = 1'b0;
    do_read(12'h044, d); check("R3 credit wrap", d, {4'd0, 12'd2, 16'd0});
    free_bufs = d[27:16] - 12'(4097);
    check("R3 free across wrap", {20'd0, free_bufs}, 32'd1);

    // R5 byte total wrap
    bytes_queued = 1'b1;
    queue_len = 16'hFFFF;
    repeat (65537) @(negedge clk);
    bytes_queued = 1'b0;
    do_read(12'h060, d); check("R5 total at max", d, 32'hFFFF_FFFF);
    bytes_queued = 1'b1;
    queue_len = 16'd2;
    @(negedge clk);
    bytes_queued = 1'b0;
    do_read(12'h060, d); check("R5 total wrapped", d, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule